// File: doc/BRIEF.md
# Data Address and Value Compare Unit

This block watches every load and store presented to it and flags a debug event before the accessing instruction is allowed to execute. Two address compare registers can each match one data address exactly, or they can work together to define a window. The window is either inclusive, hitting when the address lies inside it, or exclusive, hitting when the address lies outside it.

On top of the address test, each register can require that the data being moved also match a value register. The value test covers a single byte, a halfword or the full word. The lanes it examines come from a size select and the low bits of the address register.

Configuration is written through a simple register write port. All hit flags and the combined event are registered, so they appear one clock after the access is presented. The pipeline that uses the event is expected to hold the access for that one cycle.

Top module: `dvc_unit`

## Requirements
- R1: After a synchronous reset, every configuration register is zero and `addr_hit`, `val_hit` and `dbg_event` are low.
- R2: In exact mode (control bits [5:4] = 00 or 11), `addr_hit[i]` rises one cycle after a valid access whose address equals address register i, provided that register's enable for the access type is set.
- R3: Control bits 0 and 1 enable reads and writes for address register 0, and bits 2 and 3 do the same for register 1. An access whose type is not enabled gives no address hit.
- R4: In inclusive range mode (bits [5:4] = 01), both `addr_hit` bits are set when address register 0 <= address < address register 1 (unsigned). Register 0's type enables apply to the range.
- R5: In exclusive range mode (bits [5:4] = 10), both `addr_hit` bits are set when the address is below register 0 or at or above register 1. Register 0's type enables apply.
- R6: With value enable i set (bit 6 for i=0, bit 7 for i=1), `val_hit[i]` = `addr_hit[i]` AND data match. Only `val_hit[i]`, not the bare address hit, then feeds `dbg_event`.
- R7: Size select i (bits [9:8] for i=0, [11:10] for i=1) picks the compared lanes. 00 is the byte lane given by address register i bits [1:0]. 01 is the halfword at lanes {bit1,0} and {bit1,1}. 10 and 11 are all four lanes. Lane k is data bits [8k+7:8k]. Lanes outside the selection are ignored.
- R8: A selected lane whose byte enable is low counts as a mismatch.
- R9: With value enable i clear, `val_hit[i]` stays low and `addr_hit[i]` alone feeds `dbg_event`. `dbg_event` is the OR of the per-register contributions.
- R10: Register select codes are 0 = address 0, 1 = address 1, 2 = value 0, 3 = value 1, 4 = control (bits [11:0]). Codes 5 to 7 are ignored. A write affects accesses presented from the next cycle on.
- R11: A cycle without `acc_valid` gives all outputs low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | AW | Effective data address |
| acc_be | input | DW/8 | Byte enables of the access |
| acc_data | input | DW | Data loaded or stored |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | CW | Configuration write data |
| addr_hit | output | 2 | Per-register address hit |
| val_hit | output | 2 | Per-register value-qualified hit |
| dbg_event | output | 1 | Combined debug event |

## Verification
The hardest situation to reach is a qualified value hit. It needs an address hit, the right access type, enabled byte lanes that match the register's address offset, and equal data in those lanes, all at once. Random 32-bit stimulus almost never lines these up. The stimulus therefore draws addresses and register values from a 64-entry pool and data bytes from four values, so hits, near misses and masked lanes all occur often. Directed sequences before the random phase set up each range form and each element width at its boundaries.

// File: rtl/dvc_pkg.sv
package dvc_pkg;

  typedef enum logic [1:0] {
    RNG_NONE = 2'b00,
    RNG_IN   = 2'b01,
    RNG_OUT  = 2'b10,
    RNG_RSV  = 2'b11
  } rng_mode_e;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic [1:0] v1_size;  // [11:10]
    logic [1:0] v0_size;  // [9:8]
    logic       v1_en;    // [7]
    logic       v0_en;    // [6]
    rng_mode_e  rng;      // [5:4]
    logic       a1_wr;    // [3]
    logic       a1_rd;    // [2]
    logic       a0_wr;    // [1]
    logic       a0_rd;    // [0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] SEL_ADDR0 = 3'd0;
  localparam logic [2:0] SEL_ADDR1 = 3'd1;
  localparam logic [2:0] SEL_VAL0  = 3'd2;
  localparam logic [2:0] SEL_VAL1  = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

endpackage

// File: rtl/dvc_cfg_regs.sv
module dvc_cfg_regs
  import dvc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [CW-1:0] wdata,
  output logic [AW-1:0] addr_q [2],
  output logic [DW-1:0] val_q  [2],
  output ctrl_t         ctrl_q
);

  for (genvar i = 0; i < 2; i++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[i] <= '0;
        val_q[i]  <= '0;
      end else if (we) begin
        if (sel == (SEL_ADDR0 + 3'(i))) addr_q[i] <= wdata[AW-1:0];
        if (sel == (SEL_VAL0 + 3'(i)))  val_q[i]  <= wdata[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                           ctrl_q <= '0;
    else if (we && sel == SEL_CTRL)    ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

endmodule

// File: rtl/dvc_addr_match.sv
module dvc_addr_match
  import dvc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ref_addr [2],
  input  ctrl_t         ctrl,
  output logic [1:0]    hit
);

  logic [1:0] type_ok;
  logic [1:0] exact;
  logic       at_or_above_lo;
  logic       below_hi;
  logic       win_hit;
  logic       ranged;

  assign type_ok[0] = write ? ctrl.a0_wr : ctrl.a0_rd;
  assign type_ok[1] = write ? ctrl.a1_wr : ctrl.a1_rd;

  for (genvar i = 0; i < 2; i++) begin : g_exact
    assign exact[i] = (addr == ref_addr[i]);
  end

  assign at_or_above_lo = (addr >= ref_addr[0]);
  assign below_hi       = (addr <  ref_addr[1]);
  assign ranged         = (ctrl.rng == RNG_IN) || (ctrl.rng == RNG_OUT);

  always_comb begin
    if (ctrl.rng == RNG_IN) win_hit = at_or_above_lo && below_hi;
    else                    win_hit = !at_or_above_lo || !below_hi;
  end

  always_comb begin
    if (!valid)      hit = 2'b00;
    else if (ranged) hit = {2{win_hit && type_ok[0]}};
    else             hit = exact & type_ok;
  end

endmodule

// File: rtl/dvc_value_match.sv
module dvc_value_match
  import dvc_pkg::*;
#(
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic [DW-1:0]    data,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    ref_val,
  input  logic [LB-1:0]    ref_lo,
  input  logic [1:0]       size,
  output logic             match
);

  logic [LANES-1:0] lane_sel;
  logic [LANES-1:0] lane_ok;
  logic [LB-1:0]    half_base;

  always_comb begin
    half_base    = ref_lo;
    half_base[0] = 1'b0;
    case (size)
      SZ_BYTE: lane_sel = LANES'(1) << ref_lo;
      SZ_HALF: lane_sel = LANES'(3) << half_base;
      default: lane_sel = '1;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ok[l] = !lane_sel[l] ||
                        (be[l] && (data[8*l +: 8] == ref_val[8*l +: 8]));
  end

  assign match = &lane_ok;

endmodule

// File: rtl/dvc_unit.sv
module dvc_unit
  import dvc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32,
  localparam int LANES = DW / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [AW-1:0]    acc_addr,
  input  logic [LANES-1:0] acc_be,
  input  logic [DW-1:0]    acc_data,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [CW-1:0]    cfg_wdata,
  output logic [1:0]       addr_hit,
  output logic [1:0]       val_hit,
  output logic             dbg_event
);

  logic [AW-1:0] addr_q [2];
  logic [DW-1:0] val_q  [2];
  ctrl_t         ctrl_q;
  logic [1:0]    a_hit;
  logic [1:0]    v_match;
  logic [1:0]    v_en;
  logic [1:0]    v_hit_n;
  logic [1:0]    contrib;

  dvc_cfg_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .addr_q (addr_q),
    .val_q  (val_q),
    .ctrl_q (ctrl_q)
  );

  dvc_addr_match #(.AW(AW)) u_amatch (
    .valid    (acc_valid),
    .write    (acc_write),
    .addr     (acc_addr),
    .ref_addr (addr_q),
    .ctrl     (ctrl_q),
    .hit      (a_hit)
  );

  assign v_en = {ctrl_q.v1_en, ctrl_q.v0_en};

  for (genvar i = 0; i < 2; i++) begin : g_val
    dvc_value_match #(.DW(DW)) u_vmatch (
      .data    (acc_data),
      .be      (acc_be),
      .ref_val (val_q[i]),
      .ref_lo  (addr_q[i][LB-1:0]),
      .size    ((i == 0) ? ctrl_q.v0_size : ctrl_q.v1_size),
      .match   (v_match[i])
    );
    assign v_hit_n[i] = a_hit[i] && v_en[i] && v_match[i];
    assign contrib[i] = v_en[i] ? v_hit_n[i] : a_hit[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hit  <= '0;
      val_hit   <= '0;
      dbg_event <= 1'b0;
    end else begin
      addr_hit  <= a_hit;
      val_hit   <= v_hit_n;
      dbg_event <= |contrib;
    end
  end

endmodule

// File: rtl/dvc_unit_chk.sv
module dvc_unit_chk
  import dvc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_write,
  input logic [1:0] addr_hit,
  input logic [1:0] val_hit,
  input logic       dbg_event,
  input ctrl_t      ctrl
);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (addr_hit == 2'b00 && val_hit == 2'b00 && !dbg_event));

  p_val_needs_addr_r6: assert property (@(posedge clk) disable iff (rst)
    ((val_hit & ~addr_hit) == 2'b00));

  p_event_has_source_r9: assert property (@(posedge clk) disable iff (rst)
    dbg_event |-> (addr_hit != 2'b00));

  p_val_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !ctrl.v0_en && !ctrl.v1_en) |=> (val_hit == 2'b00));

  p_read_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && !ctrl.a0_rd && !ctrl.a1_rd) |=> (addr_hit == 2'b00));

  p_range_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (ctrl.rng == RNG_IN || ctrl.rng == RNG_OUT))
      |=> (addr_hit[0] == addr_hit[1]));

endmodule

bind dvc_unit dvc_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .addr_hit  (addr_hit),
  .val_hit   (val_hit),
  .dbg_event (dbg_event),
  .ctrl      (ctrl_q)
);

// File: tb/dvc_unit_bench.sv
`timescale 1ns/1ps
module dvc_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_data = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  addr_hit;
  logic [1:0]  val_hit;
  logic        dbg_event;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_a [2];
  logic [31:0] m_v [2];
  logic [11:0] m_c;
  logic [4:0]  exp_o;

  always #5 clk = ~clk;

  dvc_unit u_dvc_unit (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_data(acc_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .addr_hit(addr_hit), .val_hit(val_hit), .dbg_event(dbg_event)
  );

  function automatic logic [4:0] model();
    logic [1:0] ah, vh;
    logic ev;
    int mode;
    mode = m_c[5:4];
    ah = 0; vh = 0; ev = 0;
    for (int i = 0; i < 2; i++) begin
      bit ok_type, hit, ven, same;
      int sz, lo, first, count;
      if (mode == 1 || mode == 2) begin
        ok_type = acc_write ? m_c[1] : m_c[0];
        hit = (acc_addr >= m_a[0]) && (acc_addr < m_a[1]);
        if (mode == 2) hit = !hit;
      end else begin
        ok_type = acc_write ? m_c[2*i+1] : m_c[2*i];
        hit = (acc_addr == m_a[i]);
      end
      ah[i] = acc_valid && ok_type && hit;
      sz = (i == 0) ? m_c[9:8] : m_c[11:10];
      lo = m_a[i][1:0];
      if (sz == 0)      begin first = lo;      count = 1; end
      else if (sz == 1) begin first = lo & 2;  count = 2; end
      else              begin first = 0;       count = 4; end
      same = 1;
      for (int k = first; k < first + count; k++)
        if (!acc_be[k] || acc_data[8*k +: 8] != m_v[i][8*k +: 8]) same = 0;
      ven = m_c[6+i];
      vh[i] = ah[i] && ven && same;
      if (ven ? vh[i] : ah[i]) ev = 1;
    end
    return {ah, vh, ev};
  endfunction

  task automatic compare(input string tag);
    logic [4:0] got;
    got = {addr_hit, val_hit, dbg_event};
    total++;
    if (got !== exp_o) begin
      bad++;
      $display("FAIL %s t=%0t got=%b exp=%b (addr_hit,val_hit,event)", tag, $time, got, exp_o);
    end
  endtask

  task automatic cyc(input string tag, input bit v, input bit w, input logic [31:0] a,
                     input logic [3:0] be, input logic [31:0] d,
                     input bit we, input logic [2:0] s, input logic [31:0] wd);
    acc_valid = v; acc_write = w; acc_addr = a; acc_be = be; acc_data = d;
    cfg_we = we; cfg_sel = s; cfg_wdata = wd;
    @(posedge clk);
    exp_o = model();
    if (we) begin
      case (s)
        3'd0: m_a[0] = wd;
        3'd1: m_a[1] = wd;
        3'd2: m_v[0] = wd;
        3'd3: m_v[1] = wd;
        3'd4: m_c = wd[11:0];
        default: ;
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input string tag, input logic [2:0] s, input logic [31:0] wd);
    cyc(tag, 0, 0, 32'h0, 4'h0, 32'h0, 1, s, wd);
  endtask

  task automatic rd(input string tag, input logic [31:0] a, input logic [31:0] d,
                    input logic [3:0] be = 4'hf);
    cyc(tag, 1, 0, a, be, d, 0, 3'd0, 32'h0);
  endtask

  task automatic st(input string tag, input logic [31:0] a, input logic [31:0] d);
    cyc(tag, 1, 1, a, 4'hf, d, 0, 3'd0, 32'h0);
  endtask

  function automatic logic [7:0] rb();
    return 8'($urandom_range(0, 3));
  endfunction

  initial begin
    m_a[0] = 0; m_a[1] = 0; m_v[0] = 0; m_v[1] = 0; m_c = 0; exp_o = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    compare("R1");
    rd("R1", 32'h0, 32'h0);

    // R2: exact per register
    wr("R2", 3'd0, 32'h1000);
    wr("R2", 3'd1, 32'h2000);
    wr("R2", 3'd4, 32'h00f);
    rd("R2", 32'h1000, 32'h5);
    st("R2", 32'h2000, 32'h5);
    rd("R2", 32'h1004, 32'h5);
    // R3: type enables
    wr("R3", 3'd4, 32'h001);
    st("R3", 32'h1000, 32'h0);
    rd("R3", 32'h1000, 32'h0);
    wr("R3", 3'd4, 32'h008);
    rd("R3", 32'h2000, 32'h0);
    st("R3", 32'h2000, 32'h0);

    // R4: inclusive window
    wr("R4", 3'd0, 32'h100);
    wr("R4", 3'd1, 32'h200);
    wr("R4", 3'd4, 32'h013);
    rd("R4", 32'h0ff, 0); rd("R4", 32'h100, 0); rd("R4", 32'h1ff, 0); rd("R4", 32'h200, 0);
    // R5: exclusive window
    wr("R5", 3'd4, 32'h023);
    rd("R5", 32'h0ff, 0); rd("R5", 32'h100, 0); rd("R5", 32'h1ff, 0); rd("R5", 32'h200, 0);
    st("R5", 32'h300, 0);

    // R6/R7: value qualification, byte lane 2
    wr("R6", 3'd0, 32'h1002);
    wr("R6", 3'd2, 32'h00aa0000);
    wr("R6", 3'd4, 32'h043);
    rd("R6", 32'h1002, 32'h11aa2233);
    rd("R6", 32'h1002, 32'h11ab2233);
    rd("R7", 32'h1002, 32'hffaaffff);
    // R7: halfword at lanes 2,3 (register address low bits 3)
    wr("R7", 3'd0, 32'h1003);
    wr("R7", 3'd2, 32'hbeef0000);
    wr("R7", 3'd4, 32'h143);
    rd("R7", 32'h1003, 32'hbeef1234);
    rd("R7", 32'h1003, 32'hbeee1234);
    // R7: full word
    wr("R7", 3'd2, 32'hcafe0123);
    wr("R7", 3'd4, 32'h243);
    rd("R7", 32'h1003, 32'hcafe0123);
    rd("R7", 32'h1003, 32'hcafe0124);
    // R8: byte enable low on a selected lane
    rd("R8", 32'h1003, 32'hcafe0123, 4'hb);
    rd("R8", 32'h1003, 32'hcafe0123, 4'hf);
    // R9: value compare off, register 1 value on in window mode
    wr("R9", 3'd4, 32'h003);
    rd("R9", 32'h1003, 32'h0);
    wr("R9", 3'd1, 32'h2000);
    wr("R9", 3'd3, 32'h00000077);
    wr("R9", 3'd4, 32'h093);
    rd("R9", 32'h1800, 32'h77);
    rd("R9", 32'h1800, 32'h78);

    // R10: write takes effect next cycle; codes 5..7 ignored
    wr("R10", 3'd4, 32'h00f);
    cyc("R10", 1, 0, 32'h4444, 4'hf, 0, 1, 3'd0, 32'h4444);
    rd("R10", 32'h4444, 0);
    wr("R10", 3'd5, 32'h0);
    wr("R10", 3'd6, 32'h0);
    wr("R10", 3'd7, 32'h0);
    rd("R10", 32'h4444, 0);
    // R11: no valid
    cyc("R11", 0, 0, 32'h4444, 4'hf, 0, 0, 3'd0, 0);

    // mixed random traffic on a small pool
    for (int n = 0; n < 4000; n++) begin
      bit we;
      logic [2:0] s;
      logic [31:0] wd;
      we = ($urandom_range(0, 5) == 0);
      s  = 3'($urandom_range(0, 7));
      if (s == 3'd2 || s == 3'd3) wd = {rb(), rb(), rb(), rb()};
      else if (s == 3'd4)         wd = $urandom;
      else                        wd = 32'($urandom_range(0, 63));
      cyc("R6", $urandom_range(0, 3) != 0, $urandom_range(0, 1),
          32'($urandom_range(0, 63)), 4'($urandom),
          {rb(), rb(), rb(), rb()}, we, s, wd);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule